// File: doc/BRIEF.md
# Short-Frame-Sync PCM Serial Port

This block is the digital time-slot port of a telephony codec. A transmit half waits for a rising edge on its frame-sync input, copies an 8-bit sample from a parallel holding register, and sends it MSB first on a serial output. A new bit is presented on each rising edge of the transmit bit clock, and an output enable marks the eight active slots. A receive half is armed by a rising edge on its own frame-sync input. It takes one bit on each of the next eight falling edges of the receive bit clock, builds a byte, copies it to a holding register and raises a one-cycle valid strobe.

All logic runs on a fast system clock. The bit clocks, frame syncs and serial input are slow asynchronous signals. Each one passes through a synchronizer, and an edge detector turns it into a one-cycle event. The bit clock can run at any rate, and a frame can contain any number of bit clocks beyond the eight data bits. A mode input lets the receive path run from the transmit bit clock instead of its own.

Transmit states: `TX_IDLE` (output disabled), `TX_ARMED` (word loaded, waiting for a bit-clock rise) and `TX_SHIFT` (one bit per rise). The transitions are as follows. A frame-sync rise from any state goes to `TX_ARMED`. `TX_ARMED` goes to `TX_SHIFT` on a bit-clock rise. `TX_SHIFT` goes to `TX_IDLE` on the bit-clock rise after the last bit.

Receive states: `RX_IDLE`, `RX_ARMED` and `RX_CAPTURE`. The transitions are as follows. A frame-sync rise from any state goes to `RX_ARMED`. `RX_ARMED` goes to `RX_CAPTURE` on the first falling edge, which takes the MSB. `RX_CAPTURE` goes to `RX_IDLE` on the falling edge that takes the eighth bit, and that edge also fires the strobe.

Top module: `pcm_sfs_port`

## Requirements
- R1: After reset, `tx_sdata_oe` and `tx_sdata` are 0, `rx_word` is 0x00 and `rx_word_vld` is 0.
- R2: A rise of `tx_fsync` loads the transmit holding register. Bit 7 of that word appears on `tx_sdata` after the next rise of `tx_bclk`, and each later rise presents the next lower bit, down to bit 0.
- R3: `tx_sdata_oe` is 1 for exactly the eight bit slots of a word. It is 0 at all other times, and while it is 0, `tx_sdata` is 0.
- R4: If `tx_word_wr` has not been pulsed since the last frame, the next frame sends the same word again.
- R5: A write to the holding register while a word is being shifted does not change the bits in flight. The new value is sent in the next frame.
- R6: A rise of `rx_fsync` arms the receiver. The MSB is sampled on the next falling bit-clock edge, and the remaining seven bits are sampled on the seven falling edges that follow, MSB first.
- R7: After the eighth bit, `rx_word` takes the assembled byte and `rx_word_vld` is 1 for exactly one system-clock cycle. `rx_word` holds its value until the next complete word.
- R8: A frame-sync rise in the middle of a word restarts that direction. A partial receive word produces no strobe, and the transmit side reloads and restarts from bit 7.
- R9: With `sync_mode` = 1, the receive path uses `tx_bclk` and ignores `rx_bclk`. With `sync_mode` = 0, it uses `rx_bclk`, and activity on `tx_bclk` alone captures nothing.
- R10: Any number of extra bit clocks after the eighth bit leaves `tx_sdata_oe` at 0 and produces no further strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 1 | 1: receive path uses the transmit bit clock |
| tx_bclk | input | 1 | Transmit bit clock (asynchronous) |
| tx_fsync | input | 1 | Transmit frame sync; a rising edge starts a word |
| tx_word | input | WORD_W | Parallel sample to send |
| tx_word_wr | input | 1 | Writes `tx_word` into the holding register |
| tx_sdata | output | 1 | Serial transmit data |
| tx_sdata_oe | output | 1 | Output enable for `tx_sdata`; high only in active slots |
| rx_bclk | input | 1 | Receive bit clock (asynchronous) |
| rx_fsync | input | 1 | Receive frame sync; a rising edge arms capture |
| rx_sdata | input | 1 | Serial receive data |
| rx_word | output | WORD_W | Last complete received sample |
| rx_word_vld | output | 1 | One-cycle strobe when `rx_word` updates |

## Verification
The bench builds the block with its default parameters: an 8-bit word and a 2-stage synchronizer, with bit clocks at 16 system cycles per period. This leaves several system cycles of margin between each detected edge and the bench's sample point, so every slot boundary can be checked. The 8-bit word keeps the resend, mid-frame write and mid-word restart cases short, and each one can be reached in a few frames. Random frames also vary the idle bit-clock count, the clock mode and whether the receive clock toggles.

// File: rtl/pcm_sfs_pkg.sv
package pcm_sfs_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_SHIFT = 2'd2
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE    = 2'd0,
        RX_ARMED   = 2'd1,
        RX_CAPTURE = 2'd2
    } rx_state_t;
endpackage

// File: rtl/pcm_sfs_edge.sv
// Synchronizes a slow asynchronous input and emits a one-cycle pulse on
// the selected edge. STAGES must be at least 2.
module pcm_sfs_edge #(
    parameter int STAGES  = 2,
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse
);
    logic [STAGES-1:0] pipe_q;
    logic              prev_q;
    logic              level;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
            prev_q <= 1'b0;
        end else begin
            pipe_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
            prev_q <= pipe_q[STAGES-1];
        end
    end

    assign level = pipe_q[STAGES-1];

    generate
        if (FALLING) begin : g_fall
            assign pulse = ~level & prev_q;
        end else begin : g_rise
            assign pulse = level & ~prev_q;
        end
    endgenerate
endmodule

// File: rtl/pcm_sfs_tx.sv
module pcm_sfs_tx
    import pcm_sfs_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_rise,
    input  logic              fs_rise,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_wr,
    output logic              sdata,
    output logic              sdata_oe
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    tx_state_t         st_q, st_d;
    logic [WORD_W-1:0] hold_q, shift_q;
    logic [CNT_W-1:0]  idx_q;

    // next state
    always_comb begin
        st_d = st_q;
        if (fs_rise) begin
            st_d = TX_ARMED;
        end else begin
            unique case (st_q)
                TX_IDLE:  st_d = TX_IDLE;
                TX_ARMED: if (bclk_rise) st_d = TX_SHIFT;
                TX_SHIFT: if (bclk_rise && idx_q == LAST) st_d = TX_IDLE;
                default:  st_d = TX_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    // holding and shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            shift_q <= '0;
            idx_q   <= '0;
        end else begin
            if (word_wr) hold_q <= word_in;
            if (fs_rise) begin
                shift_q <= hold_q;
                idx_q   <= '0;
            end else if (st_q == TX_SHIFT && bclk_rise && idx_q != LAST) begin
                shift_q <= shift_q << 1;
                idx_q   <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        sdata_oe = (st_q == TX_SHIFT);
        sdata    = sdata_oe ? shift_q[WORD_W-1] : 1'b0;
    end

    assert_oe_opens_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe) |-> $past(bclk_rise));

    assert_bit_held_in_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_oe && $past(sdata_oe) && !$past(bclk_rise) && !$past(fs_rise)) |-> $stable(sdata));

    assert_oe_closes_on_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdata_oe) |-> $past(bclk_rise || fs_rise));
endmodule

// File: rtl/pcm_sfs_rx.sv
module pcm_sfs_rx
    import pcm_sfs_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_fall,
    input  logic              fs_rise,
    input  logic              sdata,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    rx_state_t         st_q, st_d;
    logic [WORD_W-1:0] shift_q, word_q;
    logic [WORD_W-1:0] shift_nxt;
    logic [CNT_W-1:0]  cnt_q;
    logic              vld_q;

    assign shift_nxt = {shift_q[WORD_W-2:0], sdata};

    // next state
    always_comb begin
        st_d = st_q;
        if (fs_rise) begin
            st_d = RX_ARMED;
        end else begin
            unique case (st_q)
                RX_IDLE:    st_d = RX_IDLE;
                RX_ARMED:   if (bclk_fall) st_d = RX_CAPTURE;
                RX_CAPTURE: if (bclk_fall && cnt_q == LAST) st_d = RX_IDLE;
                default:    st_d = RX_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    // capture path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            word_q  <= '0;
            cnt_q   <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (fs_rise) begin
                cnt_q <= '0;
            end else if (bclk_fall && st_q != RX_IDLE) begin
                shift_q <= shift_nxt;
                if (st_q == RX_CAPTURE && cnt_q == LAST) begin
                    word_q <= shift_nxt;
                    vld_q  <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        word_out = word_q;
        word_vld = vld_q;
    end

    assert_strobe_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    assert_strobe_follows_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(bclk_fall));

    assert_word_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> $stable(word_out));
endmodule

// File: rtl/pcm_sfs_port.sv
module pcm_sfs_port #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic              tx_bclk,
    input  logic              tx_fsync,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_word_wr,
    output logic              tx_sdata,
    output logic              tx_sdata_oe,
    input  logic              rx_bclk,
    input  logic              rx_fsync,
    input  logic              rx_sdata,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_word_vld
);
    logic tx_bclk_rise, tx_fs_rise;
    logic rx_bclk_fall, rx_fs_rise;
    logic rx_clk_src;
    logic [SYNC_STAGES-1:0] din_pipe_q;

    // R9: receive clock source selection
    assign rx_clk_src = sync_mode ? tx_bclk : rx_bclk;

    pcm_sfs_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_tx_bclk (
        .clk(clk), .rst_n(rst_n), .din(tx_bclk), .pulse(tx_bclk_rise));
    pcm_sfs_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_tx_fs (
        .clk(clk), .rst_n(rst_n), .din(tx_fsync), .pulse(tx_fs_rise));
    pcm_sfs_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_rx_bclk (
        .clk(clk), .rst_n(rst_n), .din(rx_clk_src), .pulse(rx_bclk_fall));
    pcm_sfs_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_rx_fs (
        .clk(clk), .rst_n(rst_n), .din(rx_fsync), .pulse(rx_fs_rise));

    // serial input delayed by the same depth as the clock edge path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_pipe_q <= '0;
        end else begin
            din_pipe_q[0] <= rx_sdata;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                din_pipe_q[i] <= din_pipe_q[i-1];
            end
        end
    end

    pcm_sfs_tx #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .bclk_rise(tx_bclk_rise), .fs_rise(tx_fs_rise),
        .word_in(tx_word), .word_wr(tx_word_wr),
        .sdata(tx_sdata), .sdata_oe(tx_sdata_oe));

    pcm_sfs_rx #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .bclk_fall(rx_bclk_fall), .fs_rise(rx_fs_rise),
        .sdata(din_pipe_q[SYNC_STAGES-1]),
        .word_out(rx_word), .word_vld(rx_word_vld));
endmodule

// File: tb/pcm_sfs_port_test.sv
module pcm_sfs_port_test;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_mode = 1'b0;
    logic       tx_bclk = 1'b0, tx_fsync = 1'b0, tx_word_wr = 1'b0;
    logic [7:0] tx_word = 8'h00;
    logic       tx_sdata, tx_sdata_oe;
    logic       rx_bclk = 1'b0, rx_fsync = 1'b0, rx_sdata = 1'b0;
    logic [7:0] rx_word;
    logic       rx_word_vld;

    int n_checks = 0;
    int n_fail   = 0;
    int vld_cycles = 0;
    bit [7:0] exp_hold = 8'h00;
    bit [7:0] exp_rx   = 8'h00;
    bit       wrote_since = 1'b0;

    pcm_sfs_port uut (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
        .tx_bclk(tx_bclk), .tx_fsync(tx_fsync), .tx_word(tx_word),
        .tx_word_wr(tx_word_wr), .tx_sdata(tx_sdata), .tx_sdata_oe(tx_sdata_oe),
        .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .rx_sdata(rx_sdata),
        .rx_word(rx_word), .rx_word_vld(rx_word_vld));

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n && rx_word_vld) vld_cycles++;

    function automatic bit exp_bit(bit [7:0] w, int slot);
        return w[7 - slot];
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic set_clk(bit v, bit rx_on);
        tx_bclk = v;
        rx_bclk = rx_on ? v : 1'b0;
    endtask

    task automatic write_word(bit [7:0] v);
        @(negedge clk);
        tx_word = v;
        tx_word_wr = 1'b1;
        @(negedge clk);
        tx_word_wr = 1'b0;
        exp_hold = v;
        wrote_since = 1'b1;
    endtask

    // partial word, then abandoned (R8)
    task automatic run_partial(int nbits);
        int v0 = vld_cycles;
        @(negedge clk);
        tx_fsync = 1'b1; rx_fsync = 1'b1;
        wait_half();
        for (int i = 0; i < nbits; i++) begin
            set_clk(1'b1, 1'b1);
            rx_sdata = $urandom_range(0, 1);
            wait_half();
            tx_fsync = 1'b0; rx_fsync = 1'b0;
            set_clk(1'b0, 1'b1);
            wait_half();
        end
        tx_fsync = 1'b0; rx_fsync = 1'b0;
        check(vld_cycles == v0, "R8 partial word strobe", vld_cycles - v0, 0);
    endtask

    task automatic run_frame(bit [7:0] rx_val, int extra, bit rx_on, bit expect_rx,
                             bit mid_write, bit [7:0] mid_val);
        bit [7:0] sent = exp_hold;
        string    treq = wrote_since ? "R2" : "R4";
        int       v0 = vld_cycles;
        wrote_since = 1'b0;
        @(negedge clk);
        tx_fsync = 1'b1; rx_fsync = 1'b1;
        wait_half();
        for (int i = 0; i < 8; i++) begin
            set_clk(1'b1, rx_on);
            rx_sdata = rx_val[7 - i];
            wait_half();
            if (i == 0) begin tx_fsync = 1'b0; rx_fsync = 1'b0; end
            check(tx_sdata_oe == 1'b1, "R3 oe in slot", tx_sdata_oe, 1);
            check(tx_sdata == exp_bit(sent, i), mid_write ? "R5 bit in flight" : treq,
                  tx_sdata, exp_bit(sent, i));
            set_clk(1'b0, rx_on);
            if (mid_write && i == 3) write_word(mid_val);
            wait_half();
        end
        for (int e = 0; e < extra; e++) begin
            set_clk(1'b1, rx_on);
            wait_half();
            check(tx_sdata_oe == 1'b0, "R10 oe after word", tx_sdata_oe, 0);
            check(tx_sdata == 1'b0, "R3 data low when disabled", tx_sdata, 0);
            set_clk(1'b0, rx_on);
            wait_half();
        end
        if (expect_rx) exp_rx = rx_val;
        check(vld_cycles - v0 == (expect_rx ? 1 : 0),
              expect_rx ? "R7 strobe count" : "R9 no capture", vld_cycles - v0, expect_rx ? 1 : 0);
        check(rx_word == exp_rx, expect_rx ? "R6 received word" : "R9 word unchanged",
              rx_word, exp_rx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1
        check(tx_sdata_oe == 1'b0, "R1 oe", tx_sdata_oe, 0);
        check(tx_sdata == 1'b0, "R1 data", tx_sdata, 0);
        check(rx_word == 8'h00, "R1 rx_word", rx_word, 0);
        check(rx_word_vld == 1'b0, "R1 strobe", rx_word_vld, 0);

        // directed: basic frame, R2 R6 R7
        write_word(8'hA5);
        run_frame(8'h3C, 2, 1'b1, 1'b1, 1'b0, 8'h00);
        // R4 resend without write
        run_frame(8'h81, 1, 1'b1, 1'b1, 1'b0, 8'h00);
        // R5 write mid-frame, then next frame sends it
        run_frame(8'h7E, 1, 1'b1, 1'b1, 1'b1, 8'h5A);
        run_frame(8'h01, 1, 1'b1, 1'b1, 1'b0, 8'h00);
        // R8 restart mid-word
        write_word(8'hC3);
        run_partial(3);
        run_frame(8'hE7, 2, 1'b1, 1'b1, 1'b0, 8'h00);
        // R10 long idle gap
        run_frame(8'h96, 20, 1'b1, 1'b1, 1'b0, 8'h00);
        // R9 synchronous mode, rx_bclk idle
        sync_mode = 1'b1;
        run_frame(8'h4B, 1, 1'b0, 1'b1, 1'b0, 8'h00);
        // R9 asynchronous mode, only tx_bclk toggles: no capture
        sync_mode = 1'b0;
        run_frame(8'hFF, 1, 1'b0, 1'b0, 1'b0, 8'h00);

        // random frames
        for (int k = 0; k < 30; k++) begin
            bit sm = $urandom_range(0, 1);
            bit ron;
            sync_mode = sm;
            ron = sm ? bit'($urandom_range(0, 1)) : 1'b1;
            if ($urandom_range(0, 2) != 0) write_word(8'($urandom));
            if ($urandom_range(0, 5) == 0) run_partial($urandom_range(1, 7));
            run_frame(8'($urandom), $urandom_range(1, 6), ron, 1'b1,
                      $urandom_range(0, 4) == 0, 8'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule